// File: doc/BRIEF.md
# Memory-Mapped Display, LED and Key Register Block

This block is a slave on a processor's data-memory bus. It watches the word address the core presents and claims three fixed word locations. The first holds a 32-bit value shown on a numeric display. The second holds an 8-bit LED pattern. The third is a read-only view of eight push buttons. When one of these locations is addressed, a hit flag goes high so the core's load path takes the block's read data instead of RAM data.

A store to a claimed address is captured on the rising clock edge when the write enable is high. A load returns data combinationally in the same cycle. The raw button levels pass through a two-stage synchronizer before they can be read. The display value and the LED pattern drive the block's outputs directly. Scanning the display and debouncing the buttons are left to logic outside this block.

Top module: `kled_mmio_top`

## Requirements
- R1: Reset, an asynchronous active-low input, clears the display register and the LED register to zero. Both outputs then read zero, and so do both read-backs.
- R2: A write with `bus_we` high to address 0x8000 stores all 32 bits of `bus_wdata` at the next rising edge. The stored value appears on `disp_value` and reads back at 0x8000.
- R3: A write to address 0x8004 stores only `bus_wdata[7:0]` in the LED register, and `led_drive[i]` equals stored bit i, where bit 0 is the rightmost LED. A read of 0x8004 returns the stored byte in bits [7:0] and zero in bits [31:8].
- R4: A read of address 0x8008 returns the synchronized button levels in bits [7:0] and zero in bits [31:8]. Bit i is `btn_raw[i]`, where bit 0 is the rightmost button.
- R5: A write to 0x8008 changes neither the display nor the LED register, and the button read-back still shows the button levels.
- R6: A change on `btn_raw` appears in the 0x8008 read-back after exactly two rising edges. After one edge the read-back still shows the old level.
- R7: `bus_hit` is high exactly when `bus_addr` equals 0x8000, 0x8004 or 0x8008. It is low for every other address, including 0x800C, the unaligned 0x8002, 0x0000 and 0x18000.
- R8: When `bus_hit` is low, `bus_rdata` is zero, and a write with `bus_we` high changes no register.
- R9: With `bus_we` low, no register changes, whatever the address and write data.
- R10: Read data follows `bus_addr` in the same cycle, with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; registers update on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 32 | Byte address of the data access |
| bus_wdata | input | 32 | Store data |
| bus_we | input | 1 | Store strobe for the current cycle |
| btn_raw | input | 8 | Unsynchronized button levels, bit 0 rightmost |
| bus_rdata | output | 32 | Load data for a claimed address, zero otherwise |
| bus_hit | output | 1 | High when the address is one of the three claimed words |
| disp_value | output | 32 | Current display register contents |
| led_drive | output | 8 | Current LED pattern, bit 0 rightmost |

## Verification
Full-word patterns such as 0xDEADBEEF are stored at the display address. These show that all 32 bits are kept, and they are distinguishable from the masked LED path. Writes to the LED address carry nonzero upper bytes, such as 0x12345681 and 0xFFFFFF00, so any leak past bit 7 shows up in the read-back. All-ones writes to the key address separate a read-only register from a writable one. Near-miss addresses (0x800C, 0x8002, 0x18000) expose a decoder that checks too few address bits. A stepped button change, sampled one and two edges later, pins down the synchronizer depth.

// File: rtl/kled_mmio_pkg.sv
package kled_mmio_pkg;

    // Word offsets from the block base; the core's software depends on them.
    localparam logic [3:0] OFS_DISP = 4'h0;
    localparam logic [3:0] OFS_LED  = 4'h4;
    localparam logic [3:0] OFS_KEYS = 4'h8;

    typedef enum logic [1:0] {
        SEL_NONE = 2'd0,
        SEL_DISP = 2'd1,
        SEL_LED  = 2'd2,
        SEL_KEYS = 2'd3
    } mmio_sel_e;

endpackage

// File: rtl/kled_mmio_decode.sv
module kled_mmio_decode
    import kled_mmio_pkg::*;
#(
    parameter int          ADDR_W    = 32,
    parameter logic [31:0] BASE_ADDR = 32'h0000_8000
) (
    input  logic [ADDR_W-1:0] addr,
    output mmio_sel_e         sel,
    output logic              hit
);

    localparam logic [ADDR_W-1:0] DISP_A = ADDR_W'(BASE_ADDR) + ADDR_W'(OFS_DISP);
    localparam logic [ADDR_W-1:0] LED_A  = ADDR_W'(BASE_ADDR) + ADDR_W'(OFS_LED);
    localparam logic [ADDR_W-1:0] KEYS_A = ADDR_W'(BASE_ADDR) + ADDR_W'(OFS_KEYS);

    // Full-width compare: only the three exact word addresses are claimed.
    always_comb begin
        sel = SEL_NONE;
        if (addr == DISP_A) begin
            sel = SEL_DISP;
        end else if (addr == LED_A) begin
            sel = SEL_LED;
        end else if (addr == KEYS_A) begin
            sel = SEL_KEYS;
        end
        hit = (sel != SEL_NONE);
    end

endmodule

// File: rtl/kled_btn_sync.sv
module kled_btn_sync #(
    parameter int WIDTH  = 8,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] raw,
    output logic [WIDTH-1:0] synced
);

    localparam int LAST = STAGES - 1;

    typedef logic [STAGES-1:0][WIDTH-1:0] chain_t;

    chain_t chain_d, chain_q;

    always_comb begin
        chain_d[0] = raw;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign synced = chain_q[LAST];

    // R6: the output moves only to what the previous stage held one edge earlier
    assert_sync_shift_R6: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (synced == $past(chain_q[LAST-1])));

endmodule

// File: rtl/kled_mmio_regs.sv
module kled_mmio_regs
    import kled_mmio_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int LED_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  mmio_sel_e         sel,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] disp,
    output logic [LED_W-1:0]  led
);

    typedef struct packed {
        logic [DATA_W-1:0] disp;
        logic [LED_W-1:0]  led;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            unique case (sel)
                SEL_DISP: st_d.disp = wdata;
                SEL_LED:  st_d.led  = wdata[LED_W-1:0];
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign disp = st_q.disp;
    assign led  = st_q.led;

    assert_disp_store_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_DISP) |=> (disp == $past(wdata)));

    assert_led_store_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_LED) |=> (led == $past(wdata[LED_W-1:0])));

    assert_keys_readonly_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (we && sel == SEL_KEYS) |=> ($stable(disp) && $stable(led)));

    assert_miss_nowrite_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_NONE) |=> ($stable(disp) && $stable(led)));

    assert_idle_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!we) |=> ($stable(disp) && $stable(led)));

endmodule

// File: rtl/kled_mmio_top.sv
module kled_mmio_top
    import kled_mmio_pkg::*;
#(
    parameter int          ADDR_W      = 32,
    parameter int          DATA_W      = 32,
    parameter int          LED_W       = 8,
    parameter int          BTN_W       = 8,
    parameter int          SYNC_STAGES = 2,
    parameter logic [31:0] BASE_ADDR   = 32'h0000_8000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              bus_we,
    input  logic [BTN_W-1:0]  btn_raw,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_hit,
    output logic [DATA_W-1:0] disp_value,
    output logic [LED_W-1:0]  led_drive
);

    localparam int LED_PAD = DATA_W - LED_W;
    localparam int BTN_PAD = DATA_W - BTN_W;

    mmio_sel_e        sel;
    logic [BTN_W-1:0] keys_sync;

    kled_mmio_decode #(
        .ADDR_W    (ADDR_W),
        .BASE_ADDR (BASE_ADDR)
    ) u_decode (
        .addr (bus_addr),
        .sel  (sel),
        .hit  (bus_hit)
    );

    kled_mmio_regs #(
        .DATA_W (DATA_W),
        .LED_W  (LED_W)
    ) u_regs (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (sel),
        .we    (bus_we),
        .wdata (bus_wdata),
        .disp  (disp_value),
        .led   (led_drive)
    );

    kled_btn_sync #(
        .WIDTH  (BTN_W),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .raw    (btn_raw),
        .synced (keys_sync)
    );

    // Load path: zero-extended narrow registers, zero on a miss.
    always_comb begin
        unique case (sel)
            SEL_DISP: bus_rdata = disp_value;
            SEL_LED:  bus_rdata = {{LED_PAD{1'b0}}, led_drive};
            SEL_KEYS: bus_rdata = {{BTN_PAD{1'b0}}, keys_sync};
            default:  bus_rdata = '0;
        endcase
    end

    assert_hit_aligned_R7: assert property (@(posedge clk) disable iff (!rst_n)
        bus_hit |-> (bus_addr[1:0] == 2'b00));

    assert_miss_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!bus_hit) |-> (bus_rdata == '0));

    assert_led_upper_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_LED) |-> (bus_rdata[DATA_W-1:LED_W] == '0));

    assert_keys_upper_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == SEL_KEYS) |-> (bus_rdata[DATA_W-1:BTN_W] == '0));

endmodule

// File: tb/kled_mmio_top_tb_top.sv
module kled_mmio_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_we = 1'b0;
    logic [7:0]  btn_raw = '0;
    logic [31:0] bus_rdata;
    logic        bus_hit;
    logic [31:0] disp_value;
    logic [7:0]  led_drive;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;  // 125 MHz

    kled_mmio_top dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_we     (bus_we),
        .btn_raw    (btn_raw),
        .bus_rdata  (bus_rdata),
        .bus_hit    (bus_hit),
        .disp_value (disp_value),
        .led_drive  (led_drive)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic [31:0] wdata;
        logic        we;
        logic        hit;
        logic [31:0] disp;
        logic [7:0]  led;
        logic [31:0] rd;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 12;
    // Buttons held at 8'hA5 while the table runs.
    localparam vec_t VECS [NV] = '{
        '{32'h8000, 32'hDEADBEEF, 1'b1, 1'b1, 32'hDEADBEEF, 8'h00, 32'hDEADBEEF, 8'd2},  // R2
        '{32'h8004, 32'h12345681, 1'b1, 1'b1, 32'hDEADBEEF, 8'h81, 32'h00000081, 8'd3},  // R3
        '{32'h8008, 32'hFFFFFFFF, 1'b1, 1'b1, 32'hDEADBEEF, 8'h81, 32'h000000A5, 8'd5},  // R5
        '{32'h800C, 32'h11111111, 1'b1, 1'b0, 32'hDEADBEEF, 8'h81, 32'h00000000, 8'd7},  // R7
        '{32'h8002, 32'h00000000, 1'b1, 1'b0, 32'hDEADBEEF, 8'h81, 32'h00000000, 8'd7},  // R7
        '{32'h0000, 32'h00000000, 1'b1, 1'b0, 32'hDEADBEEF, 8'h81, 32'h00000000, 8'd8},  // R8
        '{32'h18000,32'h00000000, 1'b1, 1'b0, 32'hDEADBEEF, 8'h81, 32'h00000000, 8'd8},  // R8
        '{32'h8000, 32'h00000000, 1'b0, 1'b1, 32'hDEADBEEF, 8'h81, 32'hDEADBEEF, 8'd9},  // R9
        '{32'h8004, 32'h000000FF, 1'b0, 1'b1, 32'hDEADBEEF, 8'h81, 32'h00000081, 8'd9},  // R9
        '{32'h8000, 32'h00000001, 1'b1, 1'b1, 32'h00000001, 8'h81, 32'h00000001, 8'd2},  // R2
        '{32'h8004, 32'hFFFFFF00, 1'b1, 1'b1, 32'h00000001, 8'h00, 32'h00000000, 8'd3},  // R3
        '{32'h8004, 32'h00000001, 1'b1, 1'b1, 32'h00000001, 8'h01, 32'h00000001, 8'd3}   // R3
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic read_at(input logic [31:0] a);
        bus_addr = a;
        bus_we   = 1'b0;
        #1;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        // R1: reset state
        repeat (2) @(negedge clk);
        check("R1", "disp after reset", disp_value, 32'h0);
        check("R1", "led after reset", {24'h0, led_drive}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        read_at(32'h8000);
        check("R1", "disp readback", bus_rdata, 32'h0);
        read_at(32'h8004);
        check("R1", "led readback", bus_rdata, 32'h0);

        btn_raw = 8'hA5;
        repeat (3) @(negedge clk);

        // Vector table
        for (int i = 0; i < NV; i++) begin
            bus_addr  = VECS[i].addr;
            bus_wdata = VECS[i].wdata;
            bus_we    = VECS[i].we;
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("hit v%0d", i),
                  {31'h0, bus_hit}, {31'h0, VECS[i].hit});
            @(negedge clk);
            bus_we = 1'b0;
            #1;
            check($sformatf("R%0d", VECS[i].req), $sformatf("disp v%0d", i),
                  disp_value, VECS[i].disp);
            check($sformatf("R%0d", VECS[i].req), $sformatf("led v%0d", i),
                  {24'h0, led_drive}, {24'h0, VECS[i].led});
            check($sformatf("R%0d", VECS[i].req), $sformatf("rdata v%0d", i),
                  bus_rdata, VECS[i].rd);
        end

        // R3: bit 0 drives the rightmost LED
        check("R3", "led bit0", {31'h0, led_drive[0]}, 32'h1);

        // R4: key register read and bit order
        read_at(32'h8008);
        check("R4", "keys A5", bus_rdata, 32'h000000A5);

        // R6: two-edge latency
        @(negedge clk);
        btn_raw = 8'h01;
        @(negedge clk);
        read_at(32'h8008);
        check("R6", "keys after one edge", bus_rdata, 32'h000000A5);
        @(negedge clk);
        #1;
        check("R6", "keys after two edges", bus_rdata, 32'h00000001);
        check("R4", "rightmost button bit0", {31'h0, bus_rdata[0]}, 32'h1);

        // R10: read data follows the address with no edge
        read_at(32'h8004);
        check("R10", "comb led", bus_rdata, 32'h00000001);
        read_at(32'h8000);
        check("R10", "comb disp", bus_rdata, 32'h00000001);
        read_at(32'h8010);
        check("R8", "miss rdata", bus_rdata, 32'h0);

        // R5: key write leaves the key readback intact
        @(negedge clk);
        bus_addr = 32'h8008; bus_wdata = 32'h0; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        #1;
        check("R5", "keys after write", bus_rdata, 32'h00000001);
        check("R5", "disp after key write", disp_value, 32'h00000001);

        // R1: reset in mid-run clears the registers again
        bus_addr = 32'h8000; bus_wdata = 32'hCAFE0001; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
        rst_n = 1'b0;
        #1;
        check("R1", "disp after mid reset", disp_value, 32'h0);
        check("R1", "led after mid reset", {24'h0, led_drive}, 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule